// File: doc/BRIEF.md
# Vector type configuration register

This block holds the architectural vector type state of a core that pairs a scalar pipeline with a vector unit. The configuration instructions present a requested type word and a requested vector length together with a one-cycle strobe. The block checks the requested element-width code and grouping-multiplier code against what the hardware supports, as set by parameters. It then stores either the legal configuration or an illegal marker, which clears every other field and forces the vector length to zero.

The stored word can be read through the control-status-register port at address 0xC21. Any write attempt at that address is refused with an illegal-instruction indication. When the build has no vector unit, every access to the address is refused. The stored value, the illegal flag and the vector length are also driven straight to the vector pipeline. After reset the register is in the illegal state, so vector instructions trap until a configuration instruction has run.

Top module: `vtype_cfg_reg`

## Requirements
- R1: After reset, vtype_o reads with only bit XLEN-1 set, vill_o is 1 and vl_o is 0.
- R2: A legal request with cfg_valid_i high is stored on the next rising edge. Mask policy goes to bit 7 and tail policy to bit 6, each stored as given (0 undisturbed, 1 agnostic). The element-width code goes to bits 5:3, the multiplier code to bits 2:0, and cfg_vl_i goes to vl_o.
- R3: An element-width code of 4 to 7 is illegal. So is a code of 0 to 3 whose width (8, 16, 32, 64 bits) exceeds MAX_SEW. Either one stores the illegal state.
- R4: A multiplier code of 4 is illegal and stores the illegal state. Codes 0 to 3 mean 1, 2, 4 and 8, and are always accepted with a legal width.
- R5: The fractional multiplier codes 5, 6 and 7 mean 1/8, 1/4 and 1/2. Such a code is legal only if the element width divided by the multiplier is no more than MAX_SEW. Otherwise it stores the illegal state.
- R6: In the illegal state, bit XLEN-1 is 1, all other bits of vtype_o are 0 and vl_o is 0.
- R7: Bits XLEN-2 down to 8 always read as 0. Requested bits at positions XLEN-1 down to 8 have no effect on the stored state.
- R8: A read (csr_req_i=1, csr_we_i=0, address 0xC21) returns the stored word on csr_rdata_o in the same cycle and raises csr_sel_o. A read in the same cycle as a configuration strobe returns the old value.
- R9: A write request at address 0xC21 raises csr_illegal_o, returns 0 on csr_rdata_o and leaves the stored state unchanged.
- R10: With HAS_VECTOR=0, every request at address 0xC21 raises csr_illegal_o and returns 0.
- R11: Without cfg_valid_i, vtype_o and vl_o hold their value.
- R12: A request at any other address raises neither csr_sel_o nor csr_illegal_o and returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_valid_i | input | 1 | One-cycle configuration strobe |
| cfg_type_i | input | XLEN | Requested type word |
| cfg_vl_i | input | VL_W | Requested vector length |
| csr_req_i | input | 1 | CSR access request |
| csr_we_i | input | 1 | CSR access is a write |
| csr_addr_i | input | 12 | CSR address |
| csr_rdata_o | output | XLEN | CSR read data |
| csr_illegal_o | output | 1 | Access raises illegal instruction |
| csr_sel_o | output | 1 | Address decoded to this register |
| vtype_o | output | XLEN | Stored type word |
| vill_o | output | 1 | Illegal flag |
| vl_o | output | VL_W | Stored vector length |

## Verification
A wrong legality decision or a stored field that is corrupted shows on vtype_o, vill_o and vl_o on the first rising edge after the strobe. This is why the bench compares these ports against its own model in every cycle. A wrong read path shows in the same cycle on csr_rdata_o, csr_sel_o and csr_illegal_o. The illegal-state invariant and the holding of state between strobes are checked continuously, so an error in either is caught within one cycle.

// File: rtl/vtype_cfg_pkg.sv
package vtype_cfg_pkg;

  typedef struct packed {
    logic       vma;
    logic       vta;
    logic [2:0] sew;
    logic [2:0] lmul;
  } vt_fields_t;

  localparam int unsigned FIELD_W = $bits(vt_fields_t);

  // legality of one (sew code, lmul code) pair against the widest supported element
  function automatic bit combo_ok(input int s, input int l, input int max_sew);
    int sew_w;
    if (s > 3) return 1'b0;
    sew_w = 8 << s;
    if (sew_w > max_sew) return 1'b0;
    if (l == 4) return 1'b0;
    if (l >= 5) return (sew_w << (8 - l)) <= max_sew;
    return 1'b1;
  endfunction

endpackage

// File: rtl/vtype_legal_chk.sv
module vtype_legal_chk #(
  parameter int unsigned MAX_SEW = 64
) (
  input  logic [2:0] sew_i,
  input  logic [2:0] lmul_i,
  output logic       legal_o
);
  localparam int unsigned NCODE = 8;
  localparam int unsigned NCOMB = NCODE * NCODE;

  logic [NCOMB-1:0] ok_tbl;

  for (genvar s = 0; s < NCODE; s++) begin : g_sew
    for (genvar l = 0; l < NCODE; l++) begin : g_lmul
      localparam bit OK = vtype_cfg_pkg::combo_ok(s, l, MAX_SEW);
      assign ok_tbl[s*NCODE+l] = OK;
    end
  end

  assign legal_o = ok_tbl[{sew_i, lmul_i}];
endmodule

// File: rtl/vtype_state.sv
module vtype_state
  import vtype_cfg_pkg::*;
#(
  parameter int unsigned VL_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            upd_i,
  input  logic            legal_i,
  input  vt_fields_t      fields_i,
  input  logic [VL_W-1:0] vl_i,
  output logic            vill_o,
  output vt_fields_t      fields_o,
  output logic [VL_W-1:0] vl_o
);
  logic            vill_q;
  vt_fields_t      fields_q;
  logic [VL_W-1:0] vl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vill_q   <= 1'b1;
      fields_q <= '0;
      vl_q     <= '0;
    end else if (upd_i) begin
      vill_q   <= ~legal_i;
      fields_q <= legal_i ? fields_i : '0;
      vl_q     <= legal_i ? vl_i : '0;
    end
  end

  assign vill_o   = vill_q;
  assign fields_o = fields_q;
  assign vl_o     = vl_q;
endmodule

// File: rtl/vtype_csr_port.sv
module vtype_csr_port #(
  parameter int unsigned XLEN       = 64,
  parameter logic [11:0] CSR_ADDR   = 12'hC21,
  parameter bit          HAS_VECTOR = 1'b1
) (
  input  logic            req_i,
  input  logic            we_i,
  input  logic [11:0]     addr_i,
  input  logic [XLEN-1:0] value_i,
  output logic            sel_o,
  output logic            illegal_o,
  output logic [XLEN-1:0] rdata_o
);
  logic hit;
  logic deny;

  assign hit = req_i && (addr_i == CSR_ADDR);

  if (HAS_VECTOR) begin : g_vec
    assign deny = hit && we_i;
  end else begin : g_novec
    assign deny = hit;
  end

  assign sel_o     = hit;
  assign illegal_o = deny;
  assign rdata_o   = (hit && !deny) ? value_i : '0;
endmodule

// File: rtl/vtype_cfg_reg.sv
module vtype_cfg_reg
  import vtype_cfg_pkg::*;
#(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned VL_W       = 16,
  parameter int unsigned MAX_SEW    = 64,
  parameter logic [11:0] CSR_ADDR   = 12'hC21,
  parameter bit          HAS_VECTOR = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_valid_i,
  input  logic [XLEN-1:0] cfg_type_i,
  input  logic [VL_W-1:0] cfg_vl_i,
  input  logic            csr_req_i,
  input  logic            csr_we_i,
  input  logic [11:0]     csr_addr_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            csr_illegal_o,
  output logic            csr_sel_o,
  output logic [XLEN-1:0] vtype_o,
  output logic            vill_o,
  output logic [VL_W-1:0] vl_o
);
  localparam int unsigned RSVD_W = XLEN - 1 - FIELD_W;

  vt_fields_t req_f;
  vt_fields_t cur_f;
  logic       req_legal;
  logic       vill;
  logic       unused_rsvd;

  assign req_f       = vt_fields_t'(cfg_type_i[FIELD_W-1:0]);
  assign unused_rsvd = ^cfg_type_i[XLEN-1:FIELD_W];

  vtype_legal_chk #(.MAX_SEW(MAX_SEW)) u_legal (
    .sew_i   (req_f.sew),
    .lmul_i  (req_f.lmul),
    .legal_o (req_legal)
  );

  vtype_state #(.VL_W(VL_W)) u_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (cfg_valid_i),
    .legal_i  (req_legal),
    .fields_i (req_f),
    .vl_i     (cfg_vl_i),
    .vill_o   (vill),
    .fields_o (cur_f),
    .vl_o     (vl_o)
  );

  assign vtype_o = {vill, {RSVD_W{1'b0}}, cur_f};
  assign vill_o  = vill;

  vtype_csr_port #(
    .XLEN       (XLEN),
    .CSR_ADDR   (CSR_ADDR),
    .HAS_VECTOR (HAS_VECTOR)
  ) u_csr (
    .req_i     (csr_req_i),
    .we_i      (csr_we_i),
    .addr_i    (csr_addr_i),
    .value_i   (vtype_o),
    .sel_o     (csr_sel_o),
    .illegal_o (csr_illegal_o),
    .rdata_o   (csr_rdata_o)
  );
endmodule

// File: rtl/vtype_cfg_chk.sv
module vtype_cfg_chk #(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned VL_W     = 16,
  parameter logic [11:0] CSR_ADDR = 12'hC21
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cfg_valid_i,
  input logic [XLEN-1:0] cfg_type_i,
  input logic [VL_W-1:0] cfg_vl_i,
  input logic            csr_req_i,
  input logic            csr_we_i,
  input logic [11:0]     csr_addr_i,
  input logic            csr_illegal_o,
  input logic            csr_sel_o,
  input logic [XLEN-1:0] vtype_o,
  input logic [VL_W-1:0] vl_o
);
  a_r6_vill_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vtype_o[XLEN-1] |-> (vtype_o[XLEN-2:0] == '0) && (vl_o == '0));

  a_r7_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vtype_o[XLEN-2:8] == '0);

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_valid_i |=> $stable(vtype_o) && $stable(vl_o));

  a_r4_lmul_rsvd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_i && (cfg_type_i[2:0] == 3'd4) |=> vtype_o[XLEN-1]);

  a_r3_sew_rsvd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_i && cfg_type_i[5] |=> vtype_o[XLEN-1]);

  a_r2_vl_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_i |=> vtype_o[XLEN-1] || (vl_o == $past(cfg_vl_i)));

  a_r9_write_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_req_i && csr_we_i && (csr_addr_i == CSR_ADDR) |-> csr_illegal_o);

  a_r12_other_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_addr_i != CSR_ADDR) |-> !csr_illegal_o && !csr_sel_o);
endmodule

bind vtype_cfg_reg vtype_cfg_chk #(
  .XLEN     (XLEN),
  .VL_W     (VL_W),
  .CSR_ADDR (CSR_ADDR)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_valid_i   (cfg_valid_i),
  .cfg_type_i    (cfg_type_i),
  .cfg_vl_i      (cfg_vl_i),
  .csr_req_i     (csr_req_i),
  .csr_we_i      (csr_we_i),
  .csr_addr_i    (csr_addr_i),
  .csr_illegal_o (csr_illegal_o),
  .csr_sel_o     (csr_sel_o),
  .vtype_o       (vtype_o),
  .vl_o          (vl_o)
);

// File: tb/vtype_cfg_reg_tb_top.sv
module vtype_cfg_reg_tb_top;
  localparam int XLEN = 64;
  localparam int VL_W = 16;
  localparam int MAXS = 32;
  localparam logic [11:0] ADDR = 12'hC21;
  localparam logic [XLEN-1:0] ILL = {1'b1, {(XLEN-1){1'b0}}};

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            v = 1'b0;
  logic [XLEN-1:0] t = '0;
  logic [VL_W-1:0] l = '0;
  logic            rq = 1'b0;
  logic            we = 1'b0;
  logic [11:0]     a = '0;

  logic [XLEN-1:0] rdata, vtype, rdata_nv, vtype_nv;
  logic            ill, sel, vill, ill_nv, sel_nv, vill_nv;
  logic [VL_W-1:0] vl, vl_nv;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vtype_cfg_reg #(.XLEN(XLEN), .VL_W(VL_W), .MAX_SEW(MAXS), .CSR_ADDR(ADDR), .HAS_VECTOR(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_valid_i(v), .cfg_type_i(t), .cfg_vl_i(l),
    .csr_req_i(rq), .csr_we_i(we), .csr_addr_i(a), .csr_rdata_o(rdata),
    .csr_illegal_o(ill), .csr_sel_o(sel), .vtype_o(vtype), .vill_o(vill), .vl_o(vl));

  vtype_cfg_reg #(.XLEN(XLEN), .VL_W(VL_W), .MAX_SEW(MAXS), .CSR_ADDR(ADDR), .HAS_VECTOR(1'b0)) dut_nv (
    .clk_i(clk), .rst_ni(rst_n), .cfg_valid_i(v), .cfg_type_i(t), .cfg_vl_i(l),
    .csr_req_i(rq), .csr_we_i(we), .csr_addr_i(a), .csr_rdata_o(rdata_nv),
    .csr_illegal_o(ill_nv), .csr_sel_o(sel_nv), .vtype_o(vtype_nv), .vill_o(vill_nv), .vl_o(vl_nv));

  // reference model state
  bit              m_vill = 1;
  int              m_vma = 0, m_vta = 0, m_sew = 0, m_lmul = 0;
  logic [VL_W-1:0] m_vl = '0;

  function automatic bit mdl_legal(int s, int lm);
    int w, den;
    if (s > 3) return 0;
    w = 8;
    for (int k = 0; k < s; k++) w = w * 2;
    if (w > MAXS) return 0;
    if (lm == 4) return 0;
    if (lm >= 5) begin
      den = (lm == 5) ? 8 : (lm == 6) ? 4 : 2;
      return (w * den) <= MAXS;
    end
    return 1;
  endfunction

  function automatic logic [XLEN-1:0] mdl_word();
    logic [XLEN-1:0] w;
    if (m_vill) return ILL;
    w = '0;
    w[7]   = m_vma[0];
    w[6]   = m_vta[0];
    w[5:3] = m_sew[2:0];
    w[2:0] = m_lmul[2:0];
    return w;
  endfunction

  task automatic chk(string tag, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit iv, logic [XLEN-1:0] it, logic [VL_W-1:0] il,
                      bit irq, bit iwe, logic [11:0] ia, string tag);
    logic [XLEN-1:0] ew;
    bit hit;
    @(negedge clk);
    v = iv; t = it; l = il; rq = irq; we = iwe; a = ia;
    #1;
    ew  = mdl_word();
    hit = irq && (ia == ADDR);
    chk(tag, "vtype", vtype, ew);
    chk(tag, "vill", {63'd0, vill}, {63'd0, m_vill});
    chk(tag, "vl", {48'd0, vl}, {48'd0, m_vl});
    chk(tag, "sel", {63'd0, sel}, {63'd0, hit});
    chk(tag, "illegal", {63'd0, ill}, {63'd0, hit && iwe});
    chk(tag, "rdata", rdata, (hit && !iwe) ? ew : '0);
    chk(tag, "nv_illegal", {63'd0, ill_nv}, {63'd0, hit});
    chk(tag, "nv_rdata", rdata_nv, '0);
    if (iv) begin
      if (mdl_legal(int'(it[5:3]), int'(it[2:0]))) begin
        m_vill = 0; m_vma = int'(it[7]); m_vta = int'(it[6]);
        m_sew = int'(it[5:3]); m_lmul = int'(it[2:0]); m_vl = il;
      end else begin
        m_vill = 1; m_vma = 0; m_vta = 0; m_sew = 0; m_lmul = 0; m_vl = '0;
      end
    end
  endtask

  function automatic logic [XLEN-1:0] tw(bit ma, bit ta, int s, int lm);
    logic [XLEN-1:0] w = '0;
    w[7] = ma; w[6] = ta; w[5:3] = s[2:0]; w[2:0] = lm[2:0];
    return w;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "vtype in reset", vtype, ILL);
    rst_n = 1'b1;
    step(0, '0, '0, 1, 0, ADDR, "R1");
    step(0, '0, '0, 0, 0, '0, "R11");
    // R2 legal configuration, then read back
    step(1, tw(0, 1, 2, 3), 16'd17, 0, 0, '0, "R2");
    step(0, '0, '0, 1, 0, ADDR, "R2");
    step(1, tw(1, 0, 0, 0), 16'd255, 0, 0, '0, "R2");
    step(0, '0, '0, 1, 0, ADDR, "R8");
    // R3 width too wide / reserved width code
    step(1, tw(0, 0, 3, 0), 16'd4, 0, 0, '0, "R3");
    step(0, '0, '0, 1, 0, ADDR, "R6");
    step(1, tw(1, 1, 1, 1), 16'd9, 0, 0, '0, "R2");
    step(1, tw(1, 1, 5, 0), 16'd9, 0, 0, '0, "R3");
    step(0, '0, '0, 0, 0, '0, "R6");
    // R4 reserved multiplier
    step(1, tw(0, 0, 0, 4), 16'd2, 0, 0, '0, "R4");
    step(1, tw(0, 0, 0, 3), 16'd2, 0, 0, '0, "R4");
    // R5 fractional multipliers against the widest element
    step(1, tw(0, 0, 0, 5), 16'd3, 0, 0, '0, "R5");
    step(1, tw(0, 1, 0, 6), 16'd3, 0, 0, '0, "R5");
    step(1, tw(1, 0, 1, 7), 16'd3, 0, 0, '0, "R5");
    step(1, tw(1, 0, 2, 7), 16'd3, 0, 0, '0, "R5");
    step(1, tw(0, 0, 1, 6), 16'd3, 0, 0, '0, "R5");
    // R7 reserved request bits ignored
    step(1, tw(1, 1, 1, 2) | {{56{1'b1}}, 8'h00}, 16'd40, 0, 0, '0, "R7");
    step(0, '0, '0, 1, 0, ADDR, "R7");
    // R8 read in the strobe cycle sees the old value
    step(1, tw(0, 0, 2, 0), 16'd6, 1, 0, ADDR, "R8");
    step(0, '0, '0, 1, 0, ADDR, "R8");
    // R9 write refused and state kept
    step(0, '0, '0, 1, 1, ADDR, "R9");
    step(0, '0, '0, 1, 0, ADDR, "R9");
    // R10 / R12 other address and no-vector build (checked every step)
    step(0, '0, '0, 1, 0, 12'hC20, "R12");
    step(0, '0, '0, 1, 1, 12'hC22, "R12");
    step(0, '0, '0, 1, 0, ADDR, "R10");
    step(0, '0, '0, 0, 0, '0, "R11");
    step(0, '0, '0, 0, 0, '0, "R11");
    for (int i = 0; i < 400; i++) begin
      logic [XLEN-1:0] rt;
      rt = {$urandom, $urandom};
      step($urandom_range(0, 1) == 1, rt, 16'($urandom), $urandom_range(0, 1) == 1,
           $urandom_range(0, 3) == 0, ($urandom_range(0, 3) == 0) ? 12'hC20 : ADDR, "R2");
    end
    step(0, '0, '0, 0, 0, '0, "R11");
    finish_run();
  end
endmodule